// File: doc/BRIEF.md
# Windowed Memory Upload Port

This block gives a host a path into several on-chip memories through two 16-bit registers. One is a write-only pointer register. The other is a data register, and every read or write of it moves 16 bits. The pointer value selects a window: X data RAM, Y data RAM, instruction RAM or the I/O space. A decoder turns the pointer into the local address of the chosen memory.

The X, Y and I/O windows hold 16-bit words. The instruction window holds 32-bit words. For those, the host makes two data accesses per word, high half first. The pointer steps by one only after a whole memory word has moved. A pointer that falls outside every window is an error: the access raises a one-cycle flag, touches no memory, and still advances the pointer.

A five-state sequencer controls the data register:
- ST_IDLE: no half-word is pending.
- ST_WR_HI: the high half of a 32-bit write is staged.
- ST_RD_W1 and ST_RD_W2: a memory read is in flight.
- ST_RD_LO: the low half of a 32-bit read is staged.

Transitions:
- ST_IDLE goes to ST_WR_HI on the first instruction-window write.
- ST_WR_HI goes to ST_IDLE on the second write.
- Any fetching read goes ST_RD_W1, then ST_RD_W2, then ST_IDLE, or ST_RD_LO if the word is 32 bits wide.
- ST_RD_LO goes to ST_IDLE on the next read.
- A pointer write sends any non-waiting state back to ST_IDLE.

Top module: `memwin_port`

## Requirements
- R1: After reset, every memory strobe, host_rvalid, host_rdata and win_err are 0.
- R2: A host write with host_sel=0 loads the pointer. A host read with host_sel=0 has no effect and produces no output event.
- R3: Pointer 0x1800 to 0x187F addresses X RAM at the same local address, 16 bits per word (x_we/x_re).
- R4: Pointer 0x5800 to 0x587F addresses Y RAM at local address pointer minus 0x4000, 16 bits per word (y_we/y_re).
- R5: Pointer 0x8030 to 0x84FF addresses instruction RAM at local address pointer minus 0x8000, 32 bits per word (i_we/i_re).
- R6: Pointer 0xC000 to 0xFFFF addresses the I/O space with the address unchanged, 16 bits per word (io_we/io_re).
- R7: On a 32-bit write, the first data write is staged and raises no strobe. The second raises i_we once, with mem_wdata = {first, second}. 16-bit writes drive mem_wdata[31:16]=0.
- R8: On a 32-bit read, the first data read raises i_re once and returns bits 31:16. The next read returns bits 15:0 with no new fetch.
- R9: The pointer steps by one after each complete word, so stepping past a window's end lands in the next region.
- R10: A pointer write discards a staged half-word. A later pair of writes forms a fresh word.
- R11: An access at a pointer outside all windows raises win_err for one cycle and no strobe. A read returns 0 with host_rvalid. The pointer still steps.
- R12: A data access in the opposite direction to a staged half starts a new word at the same pointer.
- R13: Memory strobes and win_err appear in the cycle after the host access. Fetched read data comes with host_rvalid three cycles after the access; staged or error data comes one cycle after. Host accesses made during ST_RD_W1/ST_RD_W2 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe, one cycle |
| host_rd | input | 1 | Host read strobe, one cycle (host_wr has priority) |
| host_sel | input | 1 | 0 = pointer register, 1 = data register |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Read half-word, valid with host_rvalid |
| host_rvalid | output | 1 | One-cycle pulse when host_rdata is new |
| win_err | output | 1 | One-cycle pulse on an out-of-window access |
| mem_addr | output | 16 | Local address for the memory or I/O access |
| mem_wdata | output | 32 | Write data; the 16-bit regions use bits 15:0 |
| x_we | output | 1 | X RAM write strobe |
| x_re | output | 1 | X RAM read strobe |
| x_rdata | input | 16 | X RAM data, one cycle after x_re |
| y_we | output | 1 | Y RAM write strobe |
| y_re | output | 1 | Y RAM read strobe |
| y_rdata | input | 16 | Y RAM data, one cycle after y_re |
| i_we | output | 1 | Instruction RAM write strobe |
| i_re | output | 1 | Instruction RAM read strobe |
| i_rdata | input | 32 | Instruction RAM data, one cycle after i_re |
| io_we | output | 1 | I/O write strobe |
| io_re | output | 1 | I/O read strobe |
| io_rdata | input | 16 | I/O data, one cycle after io_re |

## Verification
A wrong sequencer state or pointer shows at the ports within one cycle of the next data access. The symptoms are a strobe on the wrong region or local address, a missing or doubled i_we or i_re on 32-bit words, or a returned half taken from the wrong part of the word. Every expected strobe, error pulse and returned half-word is tied to an exact cycle after the host access that caused it. A latency slip or an extra event is therefore caught at once. An unexpected event seen when nothing is pending is also a failure.

// File: rtl/memwin_pkg.sv
package memwin_pkg;

    localparam int NUM_REGIONS = 4;

    typedef enum logic [2:0] {
        RG_X    = 3'd0,
        RG_Y    = 3'd1,
        RG_I    = 3'd2,
        RG_IO   = 3'd3,
        RG_NONE = 3'd4
    } region_t;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_WR_HI = 3'd1,
        ST_RD_W1 = 3'd2,
        ST_RD_W2 = 3'd3,
        ST_RD_LO = 3'd4
    } seq_state_t;

endpackage

// File: rtl/memwin_decode.sv
module memwin_decode
    import memwin_pkg::*;
#(
    parameter int          AW      = 16,
    parameter logic [AW-1:0] DRAM_LO = 16'h1800,
    parameter logic [AW-1:0] DRAM_HI = 16'h187F,
    parameter logic [AW-1:0] Y_BASE  = 16'h4000,
    parameter logic [AW-1:0] IRAM_LO = 16'h0030,
    parameter logic [AW-1:0] IRAM_HI = 16'h04FF,
    parameter logic [AW-1:0] I_BASE  = 16'h8000,
    parameter logic [AW-1:0] IO_BASE = 16'hC000
) (
    input  logic [AW-1:0] ptr,
    output region_t       region,
    output logic [AW-1:0] local_addr,
    output logic          wide
);
    localparam logic [AW-1:0] Y_LO = Y_BASE + DRAM_LO;
    localparam logic [AW-1:0] Y_HI = Y_BASE + DRAM_HI;
    localparam logic [AW-1:0] I_LO = I_BASE + IRAM_LO;
    localparam logic [AW-1:0] I_HI = I_BASE + IRAM_HI;

    always_comb begin
        region     = RG_NONE;
        local_addr = ptr;
        wide       = 1'b0;
        if (ptr >= DRAM_LO && ptr <= DRAM_HI) begin
            region = RG_X;
        end else if (ptr >= Y_LO && ptr <= Y_HI) begin
            region     = RG_Y;
            local_addr = ptr - Y_BASE;
        end else if (ptr >= I_LO && ptr <= I_HI) begin
            region     = RG_I;
            local_addr = ptr - I_BASE;
            wide       = 1'b1;
        end else if (ptr >= IO_BASE) begin
            region = RG_IO;
        end
    end
endmodule

// File: rtl/memwin_rdmux.sv
module memwin_rdmux
    import memwin_pkg::*;
#(
    parameter int DW = 16
) (
    input  region_t         sel,
    input  logic [DW-1:0]   x_rdata,
    input  logic [DW-1:0]   y_rdata,
    input  logic [2*DW-1:0] i_rdata,
    input  logic [DW-1:0]   io_rdata,
    output logic [2*DW-1:0] word
);
    always_comb begin
        unique case (sel)
            RG_X:    word = {{DW{1'b0}}, x_rdata};
            RG_Y:    word = {{DW{1'b0}}, y_rdata};
            RG_I:    word = i_rdata;
            RG_IO:   word = {{DW{1'b0}}, io_rdata};
            default: word = '0;
        endcase
    end
endmodule

// File: rtl/memwin_seq.sv
module memwin_seq
    import memwin_pkg::*;
#(
    parameter int          AW      = 16,
    parameter int          DW      = 16,
    parameter logic [AW-1:0] IRAM_LO = 16'h0030,
    parameter logic [AW-1:0] IRAM_HI = 16'h04FF
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   host_wr,
    input  logic                   host_rd,
    input  logic                   host_sel,
    input  logic [DW-1:0]          host_wdata,
    input  region_t                dec_region,
    input  logic [AW-1:0]          dec_local,
    input  logic                   dec_wide,
    input  logic [2*DW-1:0]        rd_word,
    output logic [AW-1:0]          ptr,
    output region_t                rd_region,
    output logic [DW-1:0]          host_rdata,
    output logic                   host_rvalid,
    output logic                   win_err,
    output logic [AW-1:0]          mem_addr,
    output logic [2*DW-1:0]        mem_wdata,
    output logic [NUM_REGIONS-1:0] we_vec,
    output logic [NUM_REGIONS-1:0] re_vec
);
    seq_state_t    state, state_nx;
    logic [DW-1:0] hi_q, lo_q;
    logic          rd_wide;
    logic          busy, acc_ptr, acc_wr, acc_rd;

    assign busy    = (state == ST_RD_W1) || (state == ST_RD_W2);
    assign acc_ptr = !busy && host_wr && !host_sel;
    assign acc_wr  = !busy && host_wr && host_sel;
    assign acc_rd  = !busy && !host_wr && host_rd && host_sel;

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE, ST_WR_HI, ST_RD_LO: begin
                if (acc_ptr) begin
                    state_nx = ST_IDLE;
                end else if (acc_wr) begin
                    if (dec_wide && state != ST_WR_HI) state_nx = ST_WR_HI;
                    else                               state_nx = ST_IDLE;
                end else if (acc_rd) begin
                    if (dec_region == RG_NONE)              state_nx = ST_IDLE;
                    else if (dec_wide && state == ST_RD_LO) state_nx = ST_IDLE;
                    else                                    state_nx = ST_RD_W1;
                end
            end
            ST_RD_W1: state_nx = ST_RD_W2;
            ST_RD_W2: state_nx = rd_wide ? ST_RD_LO : ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr         <= '0;
            rd_region   <= RG_NONE;
            rd_wide     <= 1'b0;
            hi_q        <= '0;
            lo_q        <= '0;
            host_rdata  <= '0;
            host_rvalid <= 1'b0;
            win_err     <= 1'b0;
            mem_addr    <= '0;
            mem_wdata   <= '0;
            we_vec      <= '0;
            re_vec      <= '0;
        end else begin
            we_vec      <= '0;
            re_vec      <= '0;
            host_rvalid <= 1'b0;
            win_err     <= 1'b0;
            if (acc_ptr) begin
                ptr <= host_wdata;
            end else if (acc_wr) begin
                if (dec_region == RG_NONE) begin
                    win_err <= 1'b1;
                    ptr     <= ptr + 1'b1;
                end else if (dec_wide && state != ST_WR_HI) begin
                    hi_q <= host_wdata;
                end else begin
                    we_vec[dec_region[1:0]] <= 1'b1;
                    mem_addr  <= dec_local;
                    mem_wdata <= dec_wide ? {hi_q, host_wdata} : {{DW{1'b0}}, host_wdata};
                    ptr       <= ptr + 1'b1;
                end
            end else if (acc_rd) begin
                if (dec_region == RG_NONE) begin
                    win_err     <= 1'b1;
                    host_rvalid <= 1'b1;
                    host_rdata  <= '0;
                    ptr         <= ptr + 1'b1;
                end else if (dec_wide && state == ST_RD_LO) begin
                    host_rvalid <= 1'b1;
                    host_rdata  <= lo_q;
                    ptr         <= ptr + 1'b1;
                end else begin
                    re_vec[dec_region[1:0]] <= 1'b1;
                    mem_addr  <= dec_local;
                    rd_region <= dec_region;
                    rd_wide   <= dec_wide;
                    if (!dec_wide) ptr <= ptr + 1'b1;
                end
            end else if (state == ST_RD_W2) begin
                host_rvalid <= 1'b1;
                host_rdata  <= rd_wide ? rd_word[2*DW-1:DW] : rd_word[DW-1:0];
                lo_q        <= rd_word[DW-1:0];
            end
        end
    end

    AST_ADDR_CLEARS_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        acc_ptr |=> (state == ST_IDLE)); // R10
    AST_IWE_SECOND_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        we_vec[int'(RG_I)] |-> ($past(state) == ST_WR_HI)); // R7
    AST_PTR_HOLD_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr && dec_region == RG_I && state != ST_WR_HI) |=> $stable(ptr)); // R7
    AST_LO_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_rd && state == ST_RD_LO) |=> (re_vec == '0)); // R8
    AST_ERR_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        win_err |-> (we_vec == '0 && re_vec == '0)); // R11
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({we_vec, re_vec})); // R13
    AST_IRAM_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (we_vec[int'(RG_I)] || re_vec[int'(RG_I)]) |-> (mem_addr >= IRAM_LO && mem_addr <= IRAM_HI)); // R5
endmodule

// File: rtl/memwin_port.sv
module memwin_port
    import memwin_pkg::*;
#(
    parameter int          AW      = 16,
    parameter int          DW      = 16,
    parameter logic [AW-1:0] DRAM_LO = 16'h1800,
    parameter logic [AW-1:0] DRAM_HI = 16'h187F,
    parameter logic [AW-1:0] Y_BASE  = 16'h4000,
    parameter logic [AW-1:0] IRAM_LO = 16'h0030,
    parameter logic [AW-1:0] IRAM_HI = 16'h04FF,
    parameter logic [AW-1:0] I_BASE  = 16'h8000,
    parameter logic [AW-1:0] IO_BASE = 16'hC000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            host_wr,
    input  logic            host_rd,
    input  logic            host_sel,
    input  logic [DW-1:0]   host_wdata,
    output logic [DW-1:0]   host_rdata,
    output logic            host_rvalid,
    output logic            win_err,
    output logic [AW-1:0]   mem_addr,
    output logic [2*DW-1:0] mem_wdata,
    output logic            x_we,
    output logic            x_re,
    input  logic [DW-1:0]   x_rdata,
    output logic            y_we,
    output logic            y_re,
    input  logic [DW-1:0]   y_rdata,
    output logic            i_we,
    output logic            i_re,
    input  logic [2*DW-1:0] i_rdata,
    output logic            io_we,
    output logic            io_re,
    input  logic [DW-1:0]   io_rdata
);
    logic [AW-1:0]          ptr;
    region_t                dec_region;
    logic [AW-1:0]          dec_local;
    logic                   dec_wide;
    region_t                rd_region;
    logic [2*DW-1:0]        rd_word;
    logic [NUM_REGIONS-1:0] we_vec, re_vec;

    memwin_decode #(
        .AW(AW), .DRAM_LO(DRAM_LO), .DRAM_HI(DRAM_HI), .Y_BASE(Y_BASE),
        .IRAM_LO(IRAM_LO), .IRAM_HI(IRAM_HI), .I_BASE(I_BASE), .IO_BASE(IO_BASE)
    ) u_decode (
        .ptr(ptr), .region(dec_region), .local_addr(dec_local), .wide(dec_wide)
    );

    memwin_rdmux #(.DW(DW)) u_rdmux (
        .sel(rd_region), .x_rdata(x_rdata), .y_rdata(y_rdata),
        .i_rdata(i_rdata), .io_rdata(io_rdata), .word(rd_word)
    );

    memwin_seq #(
        .AW(AW), .DW(DW), .IRAM_LO(IRAM_LO), .IRAM_HI(IRAM_HI)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .host_wr(host_wr), .host_rd(host_rd), .host_sel(host_sel), .host_wdata(host_wdata),
        .dec_region(dec_region), .dec_local(dec_local), .dec_wide(dec_wide),
        .rd_word(rd_word), .ptr(ptr), .rd_region(rd_region),
        .host_rdata(host_rdata), .host_rvalid(host_rvalid), .win_err(win_err),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .we_vec(we_vec), .re_vec(re_vec)
    );

    assign x_we  = we_vec[int'(RG_X)];
    assign y_we  = we_vec[int'(RG_Y)];
    assign i_we  = we_vec[int'(RG_I)];
    assign io_we = we_vec[int'(RG_IO)];
    assign x_re  = re_vec[int'(RG_X)];
    assign y_re  = re_vec[int'(RG_Y)];
    assign i_re  = re_vec[int'(RG_I)];
    assign io_re = re_vec[int'(RG_IO)];
endmodule

// File: tb/memwin_port_tb.sv
module memwin_port_tb;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0, rst_n = 1'b0;
    logic host_wr = 0, host_rd = 0, host_sel = 0;
    logic [15:0] host_wdata = '0, host_rdata, mem_addr;
    logic host_rvalid, win_err;
    logic [31:0] mem_wdata, i_rdata;
    logic x_we, x_re, y_we, y_re, i_we, i_re, io_we, io_re;
    logic [15:0] x_rdata, y_rdata, io_rdata;

    always #(CLK_PERIOD/2) clk = ~clk;

    memwin_port u_dut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd), .host_sel(host_sel),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .host_rvalid(host_rvalid),
        .win_err(win_err), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .x_we(x_we), .x_re(x_re), .x_rdata(x_rdata), .y_we(y_we), .y_re(y_re), .y_rdata(y_rdata),
        .i_we(i_we), .i_re(i_re), .i_rdata(i_rdata), .io_we(io_we), .io_re(io_re), .io_rdata(io_rdata)
    );

    // memory models: contents are a fixed function of the local address
    always_ff @(posedge clk) begin
        if (x_re)  x_rdata  <= mem_addr ^ 16'h1111;
        if (y_re)  y_rdata  <= mem_addr ^ 16'h2222;
        if (io_re) io_rdata <= ~mem_addr;
        if (i_re)  i_rdata  <= {mem_addr ^ 16'hA5A5, mem_addr + 16'h0101};
    end

    // event code bits: {x_we,x_re,y_we,y_re,i_we,i_re,io_we,io_re,err,rvalid}
    localparam logic [9:0] C_XWE = 10'b1000000000, C_XRE = 10'b0100000000;
    localparam logic [9:0] C_YWE = 10'b0010000000, C_YRE = 10'b0001000000;
    localparam logic [9:0] C_IWE = 10'b0000100000, C_IRE = 10'b0000010000;
    localparam logic [9:0] C_OWE = 10'b0000001000, C_ORE = 10'b0000000100;
    localparam logic [9:0] C_ERR = 10'b0000000010, C_RV  = 10'b0000000001;

    typedef struct {
        logic [9:0]  code;
        logic [15:0] addr;
        logic [31:0] data;
        int          cyc;
        string       req;
    } exp_t;

    exp_t exp_q[$];
    int   cyc = 0, n_chk = 0, n_bad = 0;
    logic [15:0] mptr = '0, mhi = '0, mlo = '0;
    int   mphase = 0; // 0 none, 1 write high staged, 2 read low staged

    always @(posedge clk) cyc++;

    // 0 X, 1 Y, 2 I, 3 IO, 4 none
    function automatic int reg_of(input logic [15:0] a);
        if (a >= 16'h1800 && a <= 16'h187F) return 0;
        if (a >= 16'h5800 && a <= 16'h587F) return 1;
        if (a >= 16'h8030 && a <= 16'h84FF) return 2;
        if (a >= 16'hC000) return 3;
        return 4;
    endfunction

    function automatic logic [15:0] loc_of(input logic [15:0] a);
        case (reg_of(a))
            1: return a - 16'h4000;
            2: return a - 16'h8000;
            default: return a;
        endcase
    endfunction

    function automatic logic [31:0] mem_val(input int r, input logic [15:0] la);
        case (r)
            0: return {16'h0, la ^ 16'h1111};
            1: return {16'h0, la ^ 16'h2222};
            2: return {la ^ 16'hA5A5, la + 16'h0101};
            default: return {16'h0, ~la};
        endcase
    endfunction

    task automatic push(input logic [9:0] code, input logic [15:0] a, input logic [31:0] d,
                        input int c, input string req);
        exp_t e;
        e.code = code; e.addr = a; e.data = d; e.cyc = c; e.req = req;
        exp_q.push_back(e);
    endtask

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: act=%h exp=%h", req, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        logic [9:0] code;
        exp_t e;
        code = {x_we, x_re, y_we, y_re, i_we, i_re, io_we, io_re, win_err, host_rvalid};
        if (rst_n && code != '0) begin
            n_chk++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL unexpected event: act code=%b addr=%h exp none", code, mem_addr);
            end else begin
                logic ok;
                e = exp_q.pop_front();
                ok = (code == e.code) && (cyc == e.cyc);
                if (code[9:2] != '0) ok = ok && (mem_addr == e.addr);
                if (code[9] || code[7] || code[5] || code[3]) ok = ok && (mem_wdata == e.data);
                if (code[0]) ok = ok && (host_rdata == e.data[15:0]);
                if (!ok) begin
                    n_bad++;
                    $display("FAIL %s: act code=%b cyc=%0d addr=%h wd=%h rd=%h exp code=%b cyc=%0d addr=%h data=%h",
                             e.req, code, cyc, mem_addr, mem_wdata, host_rdata, e.code, e.cyc, e.addr, e.data);
                end
            end
        end
    end

    task automatic set_ptr(input logic [15:0] a);
        @(negedge clk);
        host_wr = 1; host_sel = 0; host_wdata = a;
        @(negedge clk);
        host_wr = 0;
        mptr = a; mphase = 0;
    endtask

    task automatic wr_data(input logic [15:0] d, input string req);
        int r;
        logic [9:0] wc [4];
        @(negedge clk);
        wc[0] = C_XWE; wc[1] = C_YWE; wc[2] = C_IWE; wc[3] = C_OWE;
        r = reg_of(mptr);
        if (r == 4) begin
            push(C_ERR, '0, '0, cyc + 1, req); mptr++; mphase = 0;
        end else if (r == 2 && mphase != 1) begin
            mhi = d; mphase = 1;
        end else begin
            push(wc[r], loc_of(mptr), (r == 2) ? {mhi, d} : {16'h0, d}, cyc + 1, req);
            mptr++; mphase = 0;
        end
        host_wr = 1; host_sel = 1; host_wdata = d;
        @(negedge clk);
        host_wr = 0;
        @(negedge clk);
    endtask

    task automatic rd_data(input string req);
        int r;
        logic [9:0] rc [4];
        logic [31:0] v;
        @(negedge clk);
        rc[0] = C_XRE; rc[1] = C_YRE; rc[2] = C_IRE; rc[3] = C_ORE;
        r = reg_of(mptr);
        if (r == 4) begin
            push(C_ERR | C_RV, '0, '0, cyc + 1, req); mptr++; mphase = 0;
        end else if (r == 2 && mphase == 2) begin
            push(C_RV, '0, {16'h0, mlo}, cyc + 1, req); mptr++; mphase = 0;
        end else begin
            v = mem_val(r, loc_of(mptr));
            push(rc[r], loc_of(mptr), '0, cyc + 1, req);
            push(C_RV, '0, (r == 2) ? {16'h0, v[31:16]} : v, cyc + 3, req);
            if (r == 2) begin mlo = v[15:0]; mphase = 2; end
            else begin mptr++; mphase = 0; end
        end
        host_rd = 1; host_sel = 1;
        @(negedge clk);
        host_rd = 0;
        repeat (4) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R1 reset state
        chk({x_we, x_re, y_we, y_re, i_we, i_re, io_we, io_re, win_err, host_rvalid} == '0,
            "R1 strobes at reset", 0, 0);
        chk(host_rdata == '0, "R1 rdata at reset", host_rdata, 0);
        rst_n = 1;
        @(negedge clk);

        // R3 X window, R9 stepping, R13 latency
        set_ptr(16'h1800);
        wr_data(16'hAAAA, "R3 x write");
        wr_data(16'h5555, "R9 x write step");
        set_ptr(16'h187E);
        rd_data("R3 x read R13");
        rd_data("R9 x read last");
        rd_data("R9 step past window R11");

        // R4 Y window
        set_ptr(16'h5800);
        wr_data(16'h0F0F, "R4 y write");
        set_ptr(16'h587F);
        rd_data("R4 y read");

        // R6 I/O window and wrap
        set_ptr(16'hC000);
        wr_data(16'hBEEF, "R6 io write");
        set_ptr(16'hFFFF);
        rd_data("R6 io read");
        rd_data("R11 wrapped pointer read");

        // R5 R7 instruction writes
        set_ptr(16'h8030);
        wr_data(16'h1234, "R7 hi half");
        wr_data(16'h5678, "R5 R7 full word");
        wr_data(16'h9ABC, "R7 hi half 2");
        wr_data(16'hDEF0, "R7 next word");

        // R8 instruction reads at window end
        set_ptr(16'h84FE);
        rd_data("R8 hi fetch");
        rd_data("R8 lo staged");
        rd_data("R8 hi fetch last");
        rd_data("R8 lo staged last");
        rd_data("R9 R11 past instr window");

        // R10 pointer write abandons staged half
        set_ptr(16'h8040);
        wr_data(16'h1111, "R10 staged");
        set_ptr(16'h8041);
        wr_data(16'h2222, "R10 new hi");
        wr_data(16'h3333, "R10 new word");

        // R12 direction change mid-word
        set_ptr(16'h8050);
        wr_data(16'h4444, "R12 staged write");
        rd_data("R12 read restarts");
        rd_data("R12 read low");
        set_ptr(16'h8060);
        rd_data("R12 read hi");
        wr_data(16'h7777, "R12 write restarts");
        wr_data(16'h8888, "R12 write completes");

        // R11 out-of-window accesses
        set_ptr(16'h2000);
        wr_data(16'hFFFF, "R11 write ignored");
        rd_data("R11 read zero");
        set_ptr(16'h802F);
        wr_data(16'h0001, "R11 below instr window");

        // R2 reading the pointer register has no effect
        @(negedge clk);
        host_rd = 1; host_sel = 0;
        @(negedge clk);
        host_rd = 0;
        repeat (4) begin
            @(negedge clk);
            chk(host_rvalid == 1'b0, "R2 pointer read ignored", host_rvalid, 0);
        end
        rd_data("R2 pointer unchanged after ignored read");

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R13 all expected events seen", exp_q.size(), 0);
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule